// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data buses, side A and side B, through a pair of capture registers. Each direction has its own register with its own rising-edge clock. On every edge of its clock, a register captures whatever is currently present on its source bus. Capture never stops, whether or not any output is enabled.

When a bus is driven, a per-direction select picks its data source. The source is either the live value of the opposite bus, passed straight through, or the content of that direction's register. An active-low enable and a direction input decide which single bus, if any, the block drives. The bus pins are split into separate input, output and output-enable vectors, so a tri-state pad or an on-chip resolved net can be built around the block outside it.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0, whatever the other control inputs are.
- R2: While `oe_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R3: `a_oe` and `b_oe` are never 1 at the same time.
- R4: On every rising edge of `clk_ab`, the A-to-B register loads `a_in`, regardless of `oe_n`, `dir_a2b`, `sel_ab` and `sel_ba`. This includes the case where the A bus is being driven by the block itself.
- R5: On every rising edge of `clk_ba`, the B-to-A register loads `b_in`, regardless of `oe_n`, `dir_a2b`, `sel_ab` and `sel_ba`.
- R6: With `b_oe` = 1 and `sel_ab` = 0, `b_out` equals `a_in` combinationally, with no clock needed.
- R7: With `b_oe` = 1 and `sel_ab` = 1, `b_out` equals the A-to-B register content.
- R8: With `a_oe` = 1 and `sel_ba` = 0, `a_out` equals `b_in` combinationally.
- R9: With `a_oe` = 1 and `sel_ba` = 1, `a_out` equals the B-to-A register content.
- R10: In stored mode, a clock edge loads the new bus value, and that new value appears on the driven opposite bus after the same edge.
- R11: While `rst_n` is 0, both registers are cleared to 0 asynchronously. Afterwards, stored mode shows 0 on either side until the next capture.
- R12: A bus output whose enable is 0 reads all zeros (default `IDLE_ZERO` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Rising-edge capture clock of the A-to-B register |
| clk_ba | input | 1 | Rising-edge capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low global output enable |
| dir_a2b | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | Source of bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source of bus A: 0 live B, 1 stored B |
| a_in | input | W | Value observed on bus A |
| a_out | output | W | Value the block places on bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value observed on bus B |
| b_out | output | W | Value the block places on bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Two functions can fall in the same cycle. A register can capture new data while that same register is feeding the driven opposite bus in stored mode. The bench provokes this by pulsing the capture clock while stored mode is active and a fresh value sits on the source bus. It then expects the fresh value, not the old one, on the far side right after the edge. It also pulses a capture clock while the source bus is itself being driven by the block, and judges whether the driven value is the one stored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drive_e;

   function automatic drive_e pick_drive(input logic en_n, input logic to_b);
      drive_e r;
      if (en_n)
         r = DRV_NONE;
      else if (to_b)
         r = DRV_B;
      else
         r = DRV_A;
      return r;
   endfunction

endpackage

// File: rtl/xbus_store_reg.sv
module xbus_store_reg #(
   parameter int W         = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("xbus_store_reg: W must be at least 1");
   end

   if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else
            q <= d;
      end
   end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         q <= d;
      end
   end

endmodule

// File: rtl/xbus_path_mux.sv
module xbus_path_mux #(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic [W-1:0] live,
   input  logic [W-1:0] held,
   input  logic         use_held,
   input  logic         en,
   output logic [W-1:0] y
);

   logic [W-1:0] chosen;

   always_comb begin
      chosen = use_held ? held : live;
   end

   if (IDLE_ZERO) begin : g_quiet
      always_comb begin
         y = en ? chosen : '0;
      end
   end else begin : g_pass
      logic unused_en;
      assign unused_en = en;
      always_comb begin
         y = chosen;
      end
   end

endmodule

// File: rtl/xbus_drive_ctrl.sv
module xbus_drive_ctrl
   import xbus_pkg::*;
(
   input  logic oe_n,
   input  logic dir_a2b,
   output logic a_oe,
   output logic b_oe
);

   drive_e mode;

   always_comb begin
      mode = pick_drive(oe_n, dir_a2b);
      a_oe = 1'b0;
      b_oe = 1'b0;
      unique case (mode)
         DRV_A:   a_oe = 1'b1;
         DRV_B:   b_oe = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
   parameter int W         = 8,
   parameter bit HAS_RESET = 1'b1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         oe_n,
   input  logic         dir_a2b,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);

   if (W < 1 || W > 1024) begin : g_bad_w
      $error("dual_bus_xcvr: W out of range");
   end

   logic [W-1:0] a_q;
   logic [W-1:0] b_q;

   xbus_store_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_a (
      .clk   (clk_ab),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (a_q)
   );

   xbus_store_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_b (
      .clk   (clk_ba),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (b_q)
   );

   xbus_drive_ctrl u_ctrl (
      .oe_n    (oe_n),
      .dir_a2b (dir_a2b),
      .a_oe    (a_oe),
      .b_oe    (b_oe)
   );

   xbus_path_mux #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_mux_b (
      .live     (a_in),
      .held     (a_q),
      .use_held (sel_ab),
      .en       (b_oe),
      .y        (b_out)
   );

   xbus_path_mux #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_mux_a (
      .live     (b_in),
      .held     (b_q),
      .use_held (sel_ba),
      .en       (a_oe),
      .y        (a_out)
   );

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic         rst_n,
   input logic         clk_ab,
   input logic         clk_ba,
   input logic         oe_n,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_out,
   input logic         b_oe,
   input logic [W-1:0] a_q,
   input logic [W-1:0] b_q
);

   assert_isolate_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
      oe_n |-> (!a_oe && !b_oe));

   assert_one_side_R3: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !(a_oe && b_oe));

   assert_load_a_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
      1'b1 |=> (a_q == $past(a_in)));

   assert_load_b_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
      1'b1 |=> (b_q == $past(b_in)));

   assert_live_b_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (b_oe && !sel_ab) |-> (b_out == a_in));

   assert_held_b_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (b_oe && sel_ab) |-> (b_out == a_q));

   assert_live_a_R8: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (a_oe && !sel_ba) |-> (a_out == b_in));

   assert_held_a_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (a_oe && sel_ba) |-> (a_out == b_q));

   if (IDLE_ZERO) begin : g_idle
      assert_idle_b_R12: assert property (@(posedge clk_ab) disable iff (!rst_n)
         !b_oe |-> (b_out == '0));
      assert_idle_a_R12: assert property (@(posedge clk_ba) disable iff (!rst_n)
         !a_oe |-> (a_out == '0));
   end

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_chk (
   .rst_n  (rst_n),
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .oe_n   (oe_n),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_oe   (b_oe),
   .a_q    (a_q),
   .b_q    (b_q)
);

// File: tb/tb_dual_bus_xcvr.sv
`timescale 1ns/1ps
module tb_dual_bus_xcvr;

   typedef struct {
      logic [7:0] ao;
      logic [7:0] bo;
      logic       aoe;
      logic       boe;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       clk_ab = 1'b0, clk_ba = 1'b0;
   logic       oe_n = 1'b1, dir_a2b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic [7:0] ext_a = 8'h00, ext_b = 8'h00;
   logic [7:0] a_out, b_out;
   logic       a_oe, b_oe;
   wire  [7:0] a_bus, b_bus;

   // resolved buses: the block and an external agent share each net
   assign a_bus = a_oe ? a_out : 8'bz;
   assign a_bus = a_oe ? 8'bz  : ext_a;
   assign b_bus = b_oe ? b_out : 8'bz;
   assign b_bus = b_oe ? 8'bz  : ext_b;

   dual_bus_xcvr #(.W(8)) dut (
      .rst_n   (rst_n),
      .clk_ab  (clk_ab),
      .clk_ba  (clk_ba),
      .oe_n    (oe_n),
      .dir_a2b (dir_a2b),
      .sel_ab  (sel_ab),
      .sel_ba  (sel_ba),
      .a_in    (a_bus),
      .a_out   (a_out),
      .a_oe    (a_oe),
      .b_in    (b_bus),
      .b_out   (b_out),
      .b_oe    (b_oe)
   );

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic [7:0] ma = 8'h00, mb = 8'h00;   // reference copies of the two registers
   exp_t q[$];
   event chk_ev;

   function automatic exp_t model(input string tag);
      exp_t e;
      e.aoe = !oe_n && !dir_a2b;
      e.boe = !oe_n && dir_a2b;
      e.bo  = e.boe ? (sel_ab ? ma : ext_a) : 8'h00;
      e.ao  = e.aoe ? (sel_ba ? mb : ext_b) : 8'h00;
      e.tag = tag;
      return e;
   endfunction

   task automatic apply(input logic o, input logic d, input logic sa, input logic sb,
                        input logic [7:0] xa, input logic [7:0] xb, input string tag);
      @(negedge clk);
      oe_n = o; dir_a2b = d; sel_ab = sa; sel_ba = sb; ext_a = xa; ext_b = xb;
      #1;
      q.push_back(model(tag));
      -> chk_ev;
   endtask

   task automatic pulse_ab();
      exp_t e;
      @(negedge clk);
      e = model("");
      clk_ab = 1'b1;
      if (rst_n) ma = e.aoe ? e.ao : ext_a;
      #1 clk_ab = 1'b0;
   endtask

   task automatic pulse_ba();
      exp_t e;
      @(negedge clk);
      e = model("");
      clk_ba = 1'b1;
      if (rst_n) mb = e.boe ? e.bo : ext_b;
      #1 clk_ba = 1'b0;
   endtask

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (a_out !== e.ao || b_out !== e.bo || a_oe !== e.aoe || b_oe !== e.boe) begin
               n_bad++;
               $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected %h %h %b %b",
                        e.tag, a_out, b_out, a_oe, b_oe, e.ao, e.bo, e.aoe, e.boe);
            end
            n_cmp++;
            if (a_oe && b_oe) begin
               n_bad++;
               $display("FAIL R3: a_oe=%b b_oe=%b expected not both 1", a_oe, b_oe);
            end
         end
      end
   end

   initial begin
      #200us;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run incomplete, expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // reset state; capture pulses during reset must not load (R11)
      apply(1, 0, 0, 0, 8'hC3, 8'h5A, "R1 R11 R12 reset isolation");
      pulse_ab();
      pulse_ba();
      @(negedge clk);
      rst_n = 1'b1;
      apply(0, 1, 1, 0, 8'hC3, 8'h5A, "R11 stored B after reset");
      apply(0, 0, 0, 1, 8'hC3, 8'h5A, "R11 stored A after reset");

      // capture while isolated (R4, R5)
      apply(1, 1, 1, 1, 8'h3C, 8'hA5, "R1 R12 isolation");
      pulse_ab();
      pulse_ba();
      apply(0, 1, 1, 0, 8'h00, 8'h00, "R4 R7 isolated capture A");
      apply(0, 0, 0, 1, 8'h00, 8'h00, "R5 R9 isolated capture B");

      // all control combinations
      for (int i = 0; i < 16; i++) begin
         apply(i[3], i[2], i[1], i[0], 8'h96, 8'h69, "R1 R2 R6 R7 R8 R9 R12 sweep");
      end

      // live pass-through follows the bus without any clock (R6, R8)
      apply(0, 1, 0, 1, 8'h01, 8'hFF, "R6 live A->B");
      apply(0, 1, 0, 1, 8'h80, 8'hFF, "R6 live A->B");
      apply(0, 1, 0, 1, 8'hFE, 8'hFF, "R6 live A->B");
      apply(0, 0, 1, 0, 8'hFF, 8'h10, "R8 live B->A");
      apply(0, 0, 1, 0, 8'hFF, 8'hEF, "R8 live B->A");

      // capture in stored mode, same edge (R10)
      apply(0, 1, 1, 0, 8'hE1, 8'h00, "R7 stored before edge");
      pulse_ab();
      apply(0, 1, 1, 0, 8'hE1, 8'h00, "R10 new value after edge A->B");
      apply(0, 1, 1, 0, 8'h1E, 8'h00, "R7 stored holds against live change");
      pulse_ab();
      apply(0, 1, 1, 0, 8'h1E, 8'h00, "R10 second edge A->B");
      apply(0, 0, 0, 1, 8'h00, 8'h4B, "R9 stored B before edge");
      pulse_ba();
      apply(0, 0, 0, 1, 8'h00, 8'h4B, "R10 new value after edge B->A");

      // capture of a bus that the block drives itself (R4)
      apply(0, 0, 0, 0, 8'hAA, 8'h77, "R8 A driven from B");
      pulse_ab();
      apply(0, 1, 1, 0, 8'hAA, 8'h00, "R4 captured driven A bus");

      // reset mid-run clears both registers (R11)
      @(negedge clk);
      rst_n = 1'b0;
      ma = 8'h00; mb = 8'h00;
      #1 rst_n = 1'b1;
      apply(0, 1, 1, 0, 8'h55, 8'h55, "R11 mid-run reset B side");
      apply(0, 0, 0, 1, 8'h55, 8'h55, "R11 mid-run reset A side");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule